// File: doc/BRIEF.md
# Posted Write Fence Unit

This unit sits between a DMA write source and a memory fabric whose acknowledgments may come back in any order. Every write arriving upstream carries a relaxed flag. Writes with the flag set leave as soon as the downstream channel takes them and a tracking tag is free, even with many earlier writes still unacknowledged. A write with the flag clear is a barrier. It waits at the head of the queue until every earlier write has been acknowledged, and only then is it sent. This keeps a descriptor update from becoming visible before the data it describes.

All sources share a single in-order queue. Relaxed writes that arrive behind a held barrier therefore wait behind it. After a barrier has been sent, it does not stall later relaxed writes. Each write in flight is tracked by a tag from a pool of `2**TW`. The lowest free tag is given out when a write is issued, and the tag returns to the pool when its acknowledgment arrives. An acknowledgment naming a tag that is not in flight sets a sticky error flag and changes nothing else.

Top module: `wr_fence`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), the queue is empty, no tag is in flight, `outstanding` is 0, `idle` is 1, `ack_err` is 0, `dn_valid` is 0 and `up_ready` is 1.
- R2: A head write with `up_relaxed`=1 is presented on `dn_valid` even while other writes are outstanding, as long as a tag is free.
- R3: A head write with `up_relaxed`=0 is not presented until `outstanding` is 0. It is presented in the first cycle in which that holds and a tag is free.
- R4: Writes leave downstream in exactly their order of acceptance upstream. A relaxed write queued behind a held strict write also waits. While `dn_valid` is high and `dn_ready` is low, the presented payload stays unchanged.
- R5: Acknowledgments (`ack_valid` with `ack_tag`) are accepted in any order. Each one for an in-flight tag frees that tag and lowers `outstanding` by one.
- R6: `dn_tag` of an issued write is the lowest-numbered tag that is not in flight in that cycle.
- R7: While all `2**TW` tags are in flight, `up_ready` and `dn_valid` are both 0.
- R8: An acknowledgment whose tag is not in flight sets `ack_err`, which stays 1 until reset. It does not change `outstanding`.
- R9: `idle` is 1 exactly when the queue is empty and `outstanding` is 0.
- R10: `up_ready` is 0 while the queue holds `QD` writes.
- R11: `dn_addr`, `dn_data`, `dn_sid` and `dn_relaxed` carry the address, data, source id and relaxed flag of the write being issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream write request valid |
| up_ready | output | 1 | Upstream request accepted this cycle when valid |
| up_addr | input | AW | Write address |
| up_data | input | DW | Write data |
| up_sid | input | SW | Source identifier, passed through |
| up_relaxed | input | 1 | 1: may pass earlier writes; 0: barrier |
| dn_valid | output | 1 | Downstream write presented |
| dn_ready | input | 1 | Downstream takes the write |
| dn_addr | output | AW | Issued address |
| dn_data | output | DW | Issued data |
| dn_sid | output | SW | Issued source identifier |
| dn_relaxed | output | 1 | Relaxed flag of the issued write |
| dn_tag | output | TW | Tracking tag of the issued write |
| ack_valid | input | 1 | Completion acknowledgment valid |
| ack_tag | input | TW | Tag being acknowledged |
| outstanding | output | TW+1 | Number of tags in flight |
| idle | output | 1 | Queue empty and nothing in flight |
| ack_err | output | 1 | Sticky flag: acknowledgment for a tag not in flight |

## Verification
On every cycle the properties check four things: a barrier is presented only when no tag is in flight, a presented tag is never one already in use, a stalled payload holds steady, and a full tag pool blocks both sides. They also check that an acknowledged tag is released and that the error flag is set and then stays set. Other behaviour depends on history and can only be shown by the bench's scenarios. That includes preserving acceptance order across long runs, freeing tags under reverse and random acknowledgment orders, and picking the lowest free tag after scattered releases. It also includes releasing barriers at the exact cycle the last acknowledgment lands, and reset clearing a unit with writes in flight.

// File: rtl/wr_fence.sv
module wr_fence #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SW = 4,
  parameter int TW = 4,
  parameter int QD = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [AW-1:0] up_addr,
  input  logic [DW-1:0] up_data,
  input  logic [SW-1:0] up_sid,
  input  logic          up_relaxed,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [AW-1:0] dn_addr,
  output logic [DW-1:0] dn_data,
  output logic [SW-1:0] dn_sid,
  output logic          dn_relaxed,
  output logic [TW-1:0] dn_tag,
  input  logic          ack_valid,
  input  logic [TW-1:0] ack_tag,
  output logic [TW:0]   outstanding,
  output logic          idle,
  output logic          ack_err
);
  localparam int NT = 1 << TW;
  localparam int QW = (QD > 1) ? $clog2(QD) : 1;
  localparam int EW = 1 + SW + AW + DW;

  logic [EW-1:0] q_mem [QD];
  logic [QW-1:0] wp, rp;
  logic [QW:0]   qn;
  logic [NT-1:0] busy;
  logic          err_q;

  logic          have_free;
  logic [TW-1:0] free_tag;
  logic [TW:0]   cnt;

  always_comb begin
    have_free = 1'b0;
    free_tag  = '0;
    for (int i = NT - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        have_free = 1'b1;
        free_tag  = TW'(i);
      end
    end
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NT; i++) cnt = cnt + (TW+1)'(busy[i]);
  end

  logic [EW-1:0] head;
  logic          q_empty, q_full, fire, accept, ack_hit;

  assign head       = q_mem[rp];
  assign q_empty    = (qn == '0);
  assign q_full     = (qn == (QW+1)'(QD));
  assign dn_relaxed = head[EW-1];
  assign dn_sid     = head[AW+DW +: SW];
  assign dn_addr    = head[DW +: AW];
  assign dn_data    = head[DW-1:0];
  assign dn_tag     = free_tag;
  assign dn_valid   = !q_empty && have_free && (dn_relaxed || busy == '0);
  assign fire       = dn_valid && dn_ready;
  assign up_ready   = !q_full && have_free;
  assign accept     = up_valid && up_ready;
  assign ack_hit    = ack_valid && busy[ack_tag];
  assign outstanding = cnt;
  assign idle       = q_empty && (busy == '0);
  assign ack_err    = err_q;

  function automatic logic [QW-1:0] step_ptr(input logic [QW-1:0] p);
    return (p == QW'(QD - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [NT-1:0] set_m, clr_m;
  assign set_m = fire    ? (NT'(1) << free_tag) : '0;
  assign clr_m = ack_hit ? (NT'(1) << ack_tag)  : '0;

  always_ff @(posedge clk) begin
    if (accept) q_mem[wp] <= {up_relaxed, up_sid, up_addr, up_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      qn    <= '0;
      busy  <= '0;
      err_q <= 1'b0;
    end else begin
      if (accept) wp <= step_ptr(wp);
      if (fire)   rp <= step_ptr(rp);
      qn    <= qn + (QW+1)'(accept) - (QW+1)'(fire);
      busy  <= (busy & ~clr_m) | set_m;
      if (ack_valid && !busy[ack_tag]) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wr_fence_chk.sv
module wr_fence_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SW = 4,
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          up_ready,
  input logic          dn_valid,
  input logic          dn_ready,
  input logic [AW-1:0] dn_addr,
  input logic [DW-1:0] dn_data,
  input logic [SW-1:0] dn_sid,
  input logic          dn_relaxed,
  input logic [TW-1:0] dn_tag,
  input logic          ack_valid,
  input logic [TW-1:0] ack_tag,
  input logic [TW:0]   outstanding,
  input logic          idle,
  input logic          ack_err,
  input logic [(1<<TW)-1:0] busy
);
  p_strict_drained_r3: assert property (@(posedge clk) disable iff (rst)
    dn_valid && !dn_relaxed |-> busy == '0);

  p_tag_unused_r6: assert property (@(posedge clk) disable iff (rst)
    dn_valid |-> !busy[dn_tag]);

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_data)
      && $stable(dn_sid) && $stable(dn_relaxed));

  p_ack_frees_r5: assert property (@(posedge clk) disable iff (rst)
    ack_valid && busy[ack_tag] |=> !busy[$past(ack_tag)]);

  p_no_tag_r7: assert property (@(posedge clk) disable iff (rst)
    &busy |-> !up_ready && !dn_valid);

  p_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    ack_valid && !busy[ack_tag] |=> ack_err);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ack_err |=> ack_err);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    idle |-> !dn_valid && outstanding == '0);
endmodule

bind wr_fence wr_fence_chk #(.AW(AW), .DW(DW), .SW(SW), .TW(TW)) u_chk (
  .clk(clk), .rst(rst), .up_ready(up_ready), .dn_valid(dn_valid),
  .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_data(dn_data), .dn_sid(dn_sid),
  .dn_relaxed(dn_relaxed), .dn_tag(dn_tag), .ack_valid(ack_valid),
  .ack_tag(ack_tag), .outstanding(outstanding), .idle(idle),
  .ack_err(ack_err), .busy(busy));

// File: tb/sim_wr_fence.sv
module sim_wr_fence;
  localparam int AW = 32, DW = 32, SW = 4, TW = 4, QD = 4;
  localparam int NT = 1 << TW;

  logic clk = 0, rst = 1;
  logic up_valid = 0, up_relaxed = 0, dn_ready = 0, ack_valid = 0;
  logic [AW-1:0] up_addr = '0;
  logic [DW-1:0] up_data = '0;
  logic [SW-1:0] up_sid = '0;
  logic [TW-1:0] ack_tag = '0;
  logic up_ready, dn_valid, dn_relaxed, idle, ack_err;
  logic [AW-1:0] dn_addr;
  logic [DW-1:0] dn_data;
  logic [SW-1:0] dn_sid;
  logic [TW-1:0] dn_tag;
  logic [TW:0]   outstanding;

  always #5 clk = ~clk;

  wr_fence #(.AW(AW), .DW(DW), .SW(SW), .TW(TW), .QD(QD)) u0 (.*);

  int total = 0, fails = 0;
  bit done = 0;

  typedef struct packed { logic r; logic [SW-1:0] s; logic [AW-1:0] a; logic [DW-1:0] d; } req_t;
  req_t qm[$];
  bit   bset[NT];
  bit   merr;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int mcnt();
    int c = 0;
    for (int i = 0; i < NT; i++) c += bset[i];
    return c;
  endfunction

  function automatic int lowest_free();
    for (int i = 0; i < NT; i++) if (!bset[i]) return i;
    return -1;
  endfunction

  task automatic mreset();
    qm.delete();
    for (int i = 0; i < NT; i++) bset[i] = 0;
    merr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; up_valid = 0; dn_ready = 0; ack_valid = 0;
    @(negedge clk);
    rst = 0;
    mreset();
    #1;
    chk(idle === 1'b1, "R1 idle", idle, 1);
    chk(outstanding === '0, "R1 outstanding", outstanding, 0);
    chk(ack_err === 1'b0, "R1 ack_err", ack_err, 0);
    chk(dn_valid === 1'b0, "R1 dn_valid", dn_valid, 0);
    chk(up_ready === 1'b1, "R1 up_ready", up_ready, 1);
  endtask

  task automatic step(input int pv, input int pr, input int prdy, input int pack, input bit spur);
    int c, ev, t;
    bit exp_dv, exp_ur;
    @(negedge clk);
    up_valid   = ($urandom % 100) < pv;
    up_relaxed = ($urandom % 100) < pr;
    up_addr    = $urandom;
    up_data    = $urandom;
    up_sid     = SW'($urandom);
    dn_ready   = ($urandom % 100) < prdy;
    ack_valid  = 0;
    c = mcnt();
    if (spur && c < NT) begin
      t = $urandom % NT;
      while (bset[t]) t = (t + 1) % NT;
      ack_valid = 1; ack_tag = TW'(t);
    end else if (c > 0 && ($urandom % 100) < pack) begin
      t = $urandom % NT;
      while (!bset[t]) t = (t + 1) % NT;
      ack_valid = 1; ack_tag = TW'(t);
    end
    #1;
    exp_ur = (qm.size() < QD) && (c < NT);
    exp_dv = (qm.size() > 0) && (c < NT) && (qm[0].r || c == 0);
    chk(outstanding == (TW+1)'(c), "R5 outstanding", outstanding, c);
    chk(idle == (qm.size() == 0 && c == 0), "R9 idle", idle, (qm.size() == 0 && c == 0));
    chk(ack_err == merr, "R8 ack_err", ack_err, merr);
    chk(up_ready == exp_ur, (c == NT) ? "R7 up_ready" : "R10 up_ready", up_ready, exp_ur);
    chk(dn_valid == exp_dv,
        (c == NT) ? "R7 dn_valid" : (qm.size() > 0 && !qm[0].r) ? "R3 dn_valid" :
        (c > 0) ? "R2 dn_valid" : "R4 dn_valid", dn_valid, exp_dv);
    if (dn_valid && dn_ready && qm.size() > 0) begin
      ev = lowest_free();
      chk(dn_tag == TW'(ev), "R6 dn_tag", dn_tag, ev);
      chk(dn_addr == qm[0].a, "R11 dn_addr order R4", dn_addr, qm[0].a);
      chk(dn_data == qm[0].d, "R11 dn_data", dn_data, qm[0].d);
      chk(dn_sid == qm[0].s && dn_relaxed == qm[0].r, "R11 dn_sid/relaxed",
          {dn_sid, dn_relaxed}, {qm[0].s, qm[0].r});
      bset[dn_tag] = 1;
      void'(qm.pop_front());
    end
    if (up_valid && up_ready) qm.push_back('{up_relaxed, up_sid, up_addr, up_data});
    if (ack_valid) begin
      if (bset[ack_tag] && !(dn_valid && dn_ready && dn_tag == ack_tag && c == mcnt() - 1 && 0))
        bset[ack_tag] = 0;
      else merr = 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    do_reset();
    // R7: exhaust all tags with relaxed writes and no acknowledgments
    repeat (30) step(100, 100, 100, 0, 0);
    chk(outstanding == (TW+1)'(NT), "R7 pool full", outstanding, NT);
    // R5: drain in random order
    repeat (60) step(0, 100, 100, 100, 0);
    chk(outstanding == '0, "R5 drained", outstanding, 0);
    // R3/R4: barriers among relaxed writes, slow acknowledgments
    repeat (400) step(70, 60, 80, 15, 0);
    // R8: spurious acknowledgment
    step(0, 0, 0, 0, 1);
    repeat (3) step(0, 0, 100, 0, 0);
    chk(ack_err == 1'b1, "R8 sticky", ack_err, 1);
    // mixed random traffic
    repeat (3000) step(60, 75, 70, 40, 0);
    // R1: reset with writes in flight
    repeat (10) step(100, 100, 100, 0, 0);
    do_reset();
    repeat (500) step(50, 50, 60, 50, 0);
    repeat (200) step(0, 50, 100, 100, 0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule